// File: doc/BRIEF.md
# Host Shared Memory Window Decoder

This block decides, cycle by cycle, whether a host bus access belongs to the local shared memory. Each incoming access carries a kind (plain memory cycle or firmware-hub cycle), a 32-bit address and a read/write flag. When the address falls in a window whose enable is set, the block raises a claim. It also presents the address rebased to the start of that window, so local memory sees a zero-based offset.

Three fixed windows exist. Two are legacy boot ranges just below 1 MB, reached by memory cycles. The third is the top 2 MB of the 32-bit space, reached by firmware-hub cycles. A small configuration register file sits behind a byte-wide index/data port. It holds the window enables, base and size bytes for the host, and fixed read-only bytes that report no interrupt or DMA use. An activate byte gates access to every other register. The enable byte takes its reset value from two strap pins sampled during reset, so a system can boot from shared memory with no setup.

Top module: `shmw_window_dec`

## Requirements
- R1: A memory cycle (kind 0) with address 0x000F0000..0x000FFFFF is claimed exactly when bit 0 of the window-enable register (index 0xF4) is set.
- R2: A memory cycle with address 0x000E0000..0x000EFFFF is claimed only when bit 0 and bit 1 of the window-enable register are both set.
- R3: A firmware-hub cycle (kind 1) with address 0xFFE00000..0xFFFFFFFF is claimed exactly when bit 3 of the window-enable register is set. A cycle of the wrong kind for a window is never claimed by it.
- R4: The claim output follows address and kind combinationally while the valid strobe is high, for reads and writes alike. It is low whenever the valid strobe is low or no enabled window matches.
- R5: While claimed, the forwarded address equals the cycle address minus the matched window's start. When not claimed, the forwarded address is zero.
- R6: On reset, the window-enable register loads 0x00, 0x01, 0x08 or 0x09 for strap values 0, 1, 2 and 3 respectively (strap bit 0 drives enable bit 0, strap bit 1 drives enable bit 3). All other writable registers reset to 0x00.
- R7: Index 0x30 is the activate register. It is always accessible, stores only bit 0 and reads bits 7:1 as zero. While that bit is clear, writes to any other index are ignored and reads of any other index return 0x00.
- R8: Index 0x61 (host base low) reads bits 3:0 as zero. Index 0x60 and indices 0xF5, 0xF6 and 0xF7 are plain 8-bit read/write registers.
- R9: Indices 0x70 and 0x71 read 0x00, and indices 0x74 and 0x75 read 0x04, whatever is written to them. Any unimplemented index reads 0x00.
- R10: A read strobe returns data on the read-data port at the next clock edge. The read-data port holds its value while no read strobe is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_boot | input | 2 | Boot strap pins, sampled while rst is high |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_re | input | 1 | Configuration read strobe |
| cfg_rdata | output | 8 | Configuration read data, registered |
| cyc_valid | input | 1 | Host access address valid |
| cyc_kind | input | 1 | 0 = memory cycle, 1 = firmware-hub cycle |
| cyc_addr | input | 32 | Host access address |
| cyc_write | input | 1 | 1 = write, 0 = read |
| claim | output | 1 | Access belongs to shared memory |
| fwd_addr | output | 32 | Zero-based address inside the matched window |

## Verification
The hardest case to reach is a window-enable write that the activate gate silently drops. Its only visible trace is that claims and read-back stay the same. The bench writes a new enable value while the unit is inactive, then shows that firmware-hub cycles are still unclaimed. It then activates the unit and reads the enable byte back to prove it still holds its strap value. The extended legacy window also needs two bits in combination, so the bench steps the enable byte through 0x01 and 0x03 and probes both legacy windows at their edges and just outside them.

// File: rtl/shmw_pkg.sv
package shmw_pkg;

  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = 8;
  localparam int NUM_WIN = 3;

  localparam logic [IDX_W-1:0] IDX_ACT     = 8'h30;
  localparam logic [IDX_W-1:0] IDX_HBASE_H = 8'h60;
  localparam logic [IDX_W-1:0] IDX_HBASE_L = 8'h61;
  localparam logic [IDX_W-1:0] IDX_IRQ_A   = 8'h70;
  localparam logic [IDX_W-1:0] IDX_IRQ_B   = 8'h71;
  localparam logic [IDX_W-1:0] IDX_DMA_A   = 8'h74;
  localparam logic [IDX_W-1:0] IDX_DMA_B   = 8'h75;
  localparam logic [IDX_W-1:0] IDX_WEN     = 8'hF4;
  localparam logic [IDX_W-1:0] IDX_SBASE_H = 8'hF5;
  localparam logic [IDX_W-1:0] IDX_SBASE_L = 8'hF6;
  localparam logic [IDX_W-1:0] IDX_SSIZE   = 8'hF7;

  localparam logic [DATA_W-1:0] NO_IRQ_VAL = 8'h00;
  localparam logic [DATA_W-1:0] NO_DMA_VAL = 8'h04;

  // window-enable bit positions
  localparam int WEN_LEGACY = 0;
  localparam int WEN_EXT    = 1;
  localparam int WEN_FWH    = 3;

  typedef enum logic {
    KIND_MEM = 1'b0,
    KIND_FWH = 1'b1
  } cyc_kind_e;

  // window table: 0 = legacy, 1 = extended legacy, 2 = top of space
  function automatic longint unsigned win_start(input int w);
    case (w)
      0:       return 64'h0000_0000_000F_0000;
      1:       return 64'h0000_0000_000E_0000;
      default: return 64'h0000_0000_FFE0_0000;
    endcase
  endfunction

  function automatic int win_span_log2(input int w);
    return (w == 2) ? 21 : 16;
  endfunction

  function automatic logic win_kind(input int w);
    return (w == 2) ? KIND_FWH : KIND_MEM;
  endfunction

  function automatic logic [DATA_W-1:0] wen_reset(input logic [1:0] strap);
    logic [DATA_W-1:0] v;
    v = '0;
    v[WEN_LEGACY] = strap[0];
    v[WEN_FWH]    = strap[1];
    return v;
  endfunction

endpackage

// File: rtl/shmw_win_match.sv
module shmw_win_match #(
  parameter int              ADDR_W    = 32,
  parameter longint unsigned START     = 64'h000F_0000,
  parameter int              SPAN_LOG2 = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              qual,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);

  localparam logic [ADDR_W-1:0] START_V = ADDR_W'(START);
  localparam int                TAG_W   = ADDR_W - SPAN_LOG2;

  logic [TAG_W-1:0] tag_in;
  logic [TAG_W-1:0] tag_ref;

  assign tag_in  = addr[ADDR_W-1:SPAN_LOG2];
  assign tag_ref = START_V[ADDR_W-1:SPAN_LOG2];

  always_comb begin
    hit    = qual && (tag_in == tag_ref);
    offset = '0;
    if (hit) offset = ADDR_W'(addr[SPAN_LOG2-1:0]);
  end

endmodule

// File: rtl/shmw_cfg_regs.sv
module shmw_cfg_regs
  import shmw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        strap_boot,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              cfg_we,
  input  logic              cfg_re,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [DATA_W-1:0] wen,
  output logic              active
);

  logic              act_q;
  logic [DATA_W-1:0] hbase_h_q;
  logic [DATA_W-1:4] hbase_l_q;
  logic [DATA_W-1:0] wen_q;
  logic [DATA_W-1:0] sbase_h_q;
  logic [DATA_W-1:0] sbase_l_q;
  logic [DATA_W-1:0] ssize_q;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_ok;

  assign wr_ok = cfg_we && act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= 1'b0;
      hbase_h_q <= '0;
      hbase_l_q <= '0;
      wen_q     <= wen_reset(strap_boot);
      sbase_h_q <= '0;
      sbase_l_q <= '0;
      ssize_q   <= '0;
    end else begin
      if (cfg_we && cfg_idx == IDX_ACT) act_q <= cfg_wdata[0];
      if (wr_ok) begin
        case (cfg_idx)
          IDX_HBASE_H: hbase_h_q <= cfg_wdata;
          IDX_HBASE_L: hbase_l_q <= cfg_wdata[DATA_W-1:4];
          IDX_WEN:     wen_q     <= cfg_wdata;
          IDX_SBASE_H: sbase_h_q <= cfg_wdata;
          IDX_SBASE_L: sbase_l_q <= cfg_wdata;
          IDX_SSIZE:   ssize_q   <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (cfg_idx == IDX_ACT) begin
      rd_mux[0] = act_q;
    end else if (act_q) begin
      case (cfg_idx)
        IDX_HBASE_H: rd_mux = hbase_h_q;
        IDX_HBASE_L: rd_mux = {hbase_l_q, 4'b0000};
        IDX_IRQ_A,
        IDX_IRQ_B:   rd_mux = NO_IRQ_VAL;
        IDX_DMA_A,
        IDX_DMA_B:   rd_mux = NO_DMA_VAL;
        IDX_WEN:     rd_mux = wen_q;
        IDX_SBASE_H: rd_mux = sbase_h_q;
        IDX_SBASE_L: rd_mux = sbase_l_q;
        IDX_SSIZE:   rd_mux = ssize_q;
        default:     rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_re) cfg_rdata <= rd_mux;
  end

  assign wen    = wen_q;
  assign active = act_q;

endmodule

// File: rtl/shmw_window_dec.sv
module shmw_window_dec
  import shmw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        strap_boot,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              cfg_we,
  input  logic              cfg_re,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              cyc_valid,
  input  logic              cyc_kind,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              cyc_write,
  output logic              claim,
  output logic [ADDR_W-1:0] fwd_addr
);

  logic [DATA_W-1:0]               wen;
  logic                            active;
  logic [NUM_WIN-1:0]              win_on;
  logic [NUM_WIN-1:0]              win_hit;
  logic [NUM_WIN-1:0][ADDR_W-1:0]  win_off;
  logic                            unused_dir;

  // reads and writes are decoded alike
  assign unused_dir = cyc_write;

  shmw_cfg_regs i_regs (
    .clk        (clk),
    .rst        (rst),
    .strap_boot (strap_boot),
    .cfg_idx    (cfg_idx),
    .cfg_wdata  (cfg_wdata),
    .cfg_we     (cfg_we),
    .cfg_re     (cfg_re),
    .cfg_rdata  (cfg_rdata),
    .wen        (wen),
    .active     (active)
  );

  assign win_on[0] = wen[WEN_LEGACY];
  assign win_on[1] = wen[WEN_LEGACY] && wen[WEN_EXT];
  assign win_on[2] = wen[WEN_FWH];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic qual;
    assign qual = cyc_valid && win_on[w] && (cyc_kind == win_kind(w));
    shmw_win_match #(
      .ADDR_W    (ADDR_W),
      .START     (win_start(w)),
      .SPAN_LOG2 (win_span_log2(w))
    ) i_match (
      .addr   (cyc_addr),
      .qual   (qual),
      .hit    (win_hit[w]),
      .offset (win_off[w])
    );
  end

  always_comb begin
    fwd_addr = '0;
    for (int w = 0; w < NUM_WIN; w++) fwd_addr = fwd_addr | win_off[w];
    claim = |win_hit;
  end

endmodule

// File: rtl/shmw_chk.sv
module shmw_chk (
  input logic        clk,
  input logic        rst,
  input logic        cyc_valid,
  input logic        cyc_kind,
  input logic [31:0] cyc_addr,
  input logic        claim,
  input logic [31:0] fwd_addr,
  input logic [7:0]  wen,
  input logic        active,
  input logic        cfg_re,
  input logic [7:0]  cfg_idx,
  input logic [7:0]  cfg_rdata
);

  // R4
  claim_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    claim |-> cyc_valid);

  // R1
  legacy_claim_en_chk: assert property (@(posedge clk) disable iff (rst)
    (claim && !cyc_kind && cyc_addr[31:16] == 16'h000F) |-> wen[0]);

  // R2
  ext_claim_en_chk: assert property (@(posedge clk) disable iff (rst)
    (claim && cyc_addr[31:16] == 16'h000E) |-> (wen[0] && wen[1]));

  // R3
  fwh_claim_en_chk: assert property (@(posedge clk) disable iff (rst)
    (claim && cyc_kind) |-> (wen[3] && cyc_addr[31:21] == 11'h7FF));

  // R5
  fwd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !claim |-> (fwd_addr == 32'h0));

  // R5
  fwd_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    claim |-> (fwd_addr[31:21] == 11'h0));

  // R7
  gated_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_re && !active && cfg_idx != 8'h30) |=> (cfg_rdata == 8'h00));

  // R8
  base_low_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_re && cfg_idx == 8'h61) |=> (cfg_rdata[3:0] == 4'h0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_re |=> $stable(cfg_rdata));

endmodule

bind shmw_window_dec shmw_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .cyc_valid (cyc_valid),
  .cyc_kind  (cyc_kind),
  .cyc_addr  (cyc_addr),
  .claim     (claim),
  .fwd_addr  (fwd_addr),
  .wen       (wen),
  .active    (active),
  .cfg_re    (cfg_re),
  .cfg_idx   (cfg_idx),
  .cfg_rdata (cfg_rdata)
);

// File: tb/test_shmw_window_dec.sv
module test_shmw_window_dec;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  strap_boot = 2'b00;
  logic [7:0]  cfg_idx = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_re = 1'b0;
  logic [7:0]  cfg_rdata;
  logic        cyc_valid = 1'b0;
  logic        cyc_kind = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic        cyc_write = 1'b0;
  logic        claim;
  logic [31:0] fwd_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  shmw_window_dec i_shmw_window_dec (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk);
    rst = 1'b1; strap_boot = s;
    @(negedge clk); @(negedge clk);
    rst = 1'b0; strap_boot = 2'b00;
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk);
    cfg_idx = idx; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] idx, input logic [7:0] exp);
    @(negedge clk);
    cfg_idx = idx; cfg_re = 1'b1;
    @(negedge clk);
    cfg_re = 1'b0;
    check(req, {24'h0, cfg_rdata}, {24'h0, exp});
  endtask

  task automatic cyc(input string req, input logic v, input logic k, input logic [31:0] a,
                     input logic w, input logic ec, input logic [31:0] ea);
    @(negedge clk);
    cyc_valid = v; cyc_kind = k; cyc_addr = a; cyc_write = w;
    #1;
    check({req, " claim"}, {31'h0, claim}, {31'h0, ec});
    check({req, " fwd"}, fwd_addr, ea);
    cyc_valid = 1'b0;
  endtask

  // R6 R1 R3: strap reset values and default claiming
  task automatic t_strap;
    do_reset(2'b01);
    check("R6 rdata after reset", {24'h0, cfg_rdata}, 32'h0);
    cyc("R1 strap01 legacy", 1, 0, 32'h000F_1234, 0, 1, 32'h0000_1234);
    cyc("R3 strap01 fwh off", 1, 1, 32'hFFF0_0000, 0, 0, 32'h0);
    wr(8'h30, 8'h01);
    rd("R6 strap01 wen", 8'hF4, 8'h01);
    rd("R6 base hi reset", 8'h60, 8'h00);
    do_reset(2'b11);
    cyc("R3 strap11 fwh", 1, 1, 32'hFFE0_0010, 1, 1, 32'h0000_0010);
    wr(8'h30, 8'h01);
    rd("R6 strap11 wen", 8'hF4, 8'h09);
    do_reset(2'b10);
    wr(8'h30, 8'h01);
    rd("R6 strap10 wen", 8'hF4, 8'h08);
    cyc("R1 strap10 legacy off", 1, 0, 32'h000F_0000, 0, 0, 32'h0);
    do_reset(2'b00);
    wr(8'h30, 8'h01);
    rd("R6 strap00 wen", 8'hF4, 8'h00);
  endtask

  // R7: activate gate
  task automatic t_gate;
    do_reset(2'b00);
    rd("R7 act reset", 8'h30, 8'h00);
    rd("R7 gated dma read", 8'h74, 8'h00);
    wr(8'hF4, 8'h0B);
    cyc("R7 gated write no fwh claim", 1, 1, 32'hFFFF_0000, 0, 0, 32'h0);
    wr(8'h30, 8'hFF);
    rd("R7 act reads bit0", 8'h30, 8'h01);
    rd("R7 wen unchanged", 8'hF4, 8'h00);
    wr(8'hF5, 8'h5A);
    wr(8'h30, 8'h00);
    rd("R7 gated read zero", 8'hF5, 8'h00);
    wr(8'h30, 8'h01);
    rd("R8 sbase hi kept", 8'hF5, 8'h5A);
  endtask

  // R1 R2 R5: legacy windows
  task automatic t_legacy;
    do_reset(2'b00);
    wr(8'h30, 8'h01);
    wr(8'hF4, 8'h01);
    cyc("R1 legacy low edge", 1, 0, 32'h000F_0000, 0, 1, 32'h0);
    cyc("R1 legacy high edge", 1, 0, 32'h000F_FFFF, 1, 1, 32'h0000_FFFF);
    cyc("R2 ext without bit1", 1, 0, 32'h000E_0010, 0, 0, 32'h0);
    cyc("R1 above legacy", 1, 0, 32'h0010_0000, 0, 0, 32'h0);
    wr(8'hF4, 8'h03);
    cyc("R2 ext on", 1, 0, 32'h000E_0010, 0, 1, 32'h0000_0010);
    cyc("R2 ext top", 1, 0, 32'h000E_FFFF, 1, 1, 32'h0000_FFFF);
    cyc("R2 below ext", 1, 0, 32'h000D_FFFF, 0, 0, 32'h0);
    cyc("R3 fwh kind at legacy", 1, 1, 32'h000F_0000, 0, 0, 32'h0);
    wr(8'hF4, 8'h02);
    cyc("R2 bit1 alone", 1, 0, 32'h000E_0000, 0, 0, 32'h0);
  endtask

  // R3 R4 R5: top window and valid strobe
  task automatic t_fwh;
    do_reset(2'b00);
    wr(8'h30, 8'h01);
    wr(8'hF4, 8'h08);
    cyc("R3 fwh top", 1, 1, 32'hFFFF_FFFF, 0, 1, 32'h001F_FFFF);
    cyc("R4 fwh write", 1, 1, 32'hFFE0_0000, 1, 1, 32'h0);
    cyc("R3 below top window", 1, 1, 32'hFFDF_FFFF, 0, 0, 32'h0);
    cyc("R3 mem kind at top", 1, 0, 32'hFFF0_0000, 0, 0, 32'h0);
    cyc("R4 no valid", 0, 1, 32'hFFF0_0000, 0, 0, 32'h0);
  endtask

  // R8 R9 R10: register map details and read timing
  task automatic t_regs;
    do_reset(2'b00);
    wr(8'h30, 8'h01);
    wr(8'h61, 8'hAB);
    rd("R8 base lo nibble", 8'h61, 8'hA0);
    wr(8'h60, 8'h12);
    rd("R8 base hi", 8'h60, 8'h12);
    wr(8'hF7, 8'hC3);
    rd("R8 size", 8'hF7, 8'hC3);
    rd("R9 irq a", 8'h70, 8'h00);
    wr(8'h75, 8'hFF);
    rd("R9 dma b after write", 8'h75, 8'h04);
    rd("R9 dma a", 8'h74, 8'h04);
    wr(8'h71, 8'h33);
    rd("R9 irq b after write", 8'h71, 8'h00);
    rd("R9 unimplemented", 8'h50, 8'h00);
    rd("R10 load", 8'hF7, 8'hC3);
    @(negedge clk); cfg_idx = 8'h60;
    @(negedge clk); @(negedge clk);
    check("R10 hold without read", {24'h0, cfg_rdata}, 32'h0000_00C3);
  endtask

  initial begin
    t_strap;
    t_gate;
    t_legacy;
    t_fwh;
    t_regs;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule